// File: doc/BRIEF.md
# Control-Mode Handshake Engine

This block is the device side of a serial audio codec's configuration channel. While the mode pin is low (control mode), a controller shifts 64-bit control words into the block. A one-cycle frame-start strobe marks each word. The block sends the most recently accepted word back on a three-statable serial output during the next frame. One bit of each word acts as a two-phase handshake flag. The controller first sends the flag at 0 and waits to see 0 echoed. It then sends the flag at 1 and waits to see 1 echoed. After that the block ignores all further control traffic, sends the final word once more and releases its output.

A flag is not echoed at once unless two things hold: the selected clock source is one of the internal oscillators, and the source and rate fields match the previous word. Otherwise the echo waits until those fields have stayed unchanged for a programmable stability window. This window is counted in clock cycles and stands for the 2 ms settling time.

When the asynchronous mode pin rises, the block synchronises it and switches to data mode. As frame master, it lets one full clock period pass before its first frame-sync pulse. As slave, it catches a time-slot rise even when that rise arrives together with the mode pin. A configuration bit sets how fast the frame-sync driver is released when the mode pin falls again.

Top module: `ctlmode_handshake`

## Requirements
- R1: A control word is 64 bits, most significant bit first. `sdIn` carries bit 63 in the cycle in which `frameStart` is high, and one further bit in each following cycle. At each later `frameStart`, the block sends the last accepted word on `sdOut`, bit 63 first. Each bit appears one clock after the matching inbound bit, with bit 61 replaced by the current echoed flag.
- R2: The handshake flag is bit 61. The clock-source field is bits 53:52, where codes 1 and 2 are internal oscillators. The rate field is bits 50:48. A flag arriving with an internal source and with both fields equal to the previous word's is echoed in the very next frame.
- R3: Any other flag is echoed only once both fields have been unchanged for STABLE_CYCLES clocks. Frames sent before that still carry the old echoed flag. After reset, and on every return to control mode, the echoed flag is 1.
- R4: A word whose source or rate field differs from the previous word restarts the stability count.
- R5: After the flag 0 has been echoed, the next word accepted with the flag at 1 locks the block. From then on, incoming words change neither the echoed content nor the configuration bit of R9.
- R6: Once the locking flag 1 has been echoed, the next frame sends the locked word in full with bit 61 set. `sdOutEn` then goes low on the clock after the last bit and stays low for the rest of control mode.
- R7: The mode pin passes through two flops, so data mode starts two clocks after the pin rises. In data mode, `sdOut` carries `dataTx` and `sdOutEn` is 1.
- R8: As master (`isMaster` = 1), `fsyncOut` stays low at the first clock edge of data mode and is high after the second. After that it is a one-cycle pulse every 64 clocks.
- R9: Bit 55 of the last accepted word picks the release of `fsyncEn` when the mode pin falls. With 1, `fsyncEn` drops as soon as the pin falls. With 0, it drops on the second clock edge after the fall, which is within 3 clocks.
- R10: As slave, a rise of `tsIn` gives a one-cycle `slotStart` pulse two clocks later. This also holds when the rise coincides with the rise of the mode pin.
- R11: After reset the block is in control mode with `sdOutEn` = 1, and `sdOut`, `fsyncOut`, `fsyncEn` and `slotStart` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; also times the stability window |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 1 | Asynchronous mode pin: 0 = control, 1 = data |
| isMaster | input | 1 | 1 = block generates frame sync in data mode |
| frameStart | input | 1 | Marks the first bit of a control word |
| sdIn | input | 1 | Serial control data in |
| tsIn | input | 1 | Time-slot input used as slave |
| dataTx | input | 1 | Serial data bit to send in data mode |
| sdOut | output | 1 | Serial data out |
| sdOutEn | output | 1 | Output enable for `sdOut` (0 = three-state) |
| fsyncOut | output | 1 | Frame sync generated as master |
| fsyncEn | output | 1 | Output enable for `fsyncOut` |
| slotStart | output | 1 | One-cycle pulse on a detected time-slot rise |

## Verification
A stuck or early echo-flag register shows up as a wrong bit 61 in the very next echoed frame, so each frame gives a verdict within 65 clocks. A stability counter that restarts or saturates at the wrong time moves the flag change across a frame boundary. The bench places frames on both sides of the window to catch that. A lock state that fails to ignore words shows either in the content of the final echo or, later, as the wrong release timing of `fsyncEn` after the next mode-pin fall. An output that is released too early or never released shows at `sdOutEn` one clock after the final word's last bit.

// File: rtl/chs_pkg.sv
package chs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT0    = 3'd0,
    ST_ARMED    = 3'd1,
    ST_LOCKED   = 3'd2,
    ST_FINAL    = 3'd3,
    ST_SENDLAST = 3'd4,
    ST_RELEASED = 3'd5
  } hskState_t;

  typedef struct packed {
    logic capture;
    logic loadTx;
    logic clrStable;
    logic ctlClear;
  } hskStrobe_t;

endpackage

// File: rtl/chs_datapath.sv
module chs_datapath
  import chs_pkg::*;
#(
  parameter int FRAME_BITS    = 64,
  parameter int HS_POS        = 61,
  parameter int IMM_POS       = 55,
  parameter int SRC_LSB       = 52,
  parameter int SRC_W         = 2,
  parameter int RATE_LSB      = 48,
  parameter int RATE_W        = 3,
  parameter int INT_SRC_A     = 1,
  parameter int INT_SRC_B     = 2,
  parameter int STABLE_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlMode,
  input  logic       frameStart,
  input  logic       sdIn,
  input  hskStrobe_t strb,
  input  logic       echoHs,
  output logic       wordDone,
  output logic       hsNew,
  output logic       fieldChanged,
  output logic       internalSrc,
  output logic       stableOk,
  output logic       txDone,
  output logic       txBit,
  output logic       cfgImm
);

  localparam int CNT_W   = $clog2(FRAME_BITS);
  localparam int LEFT_W  = $clog2(FRAME_BITS + 1);
  localparam int FIELD_W = SRC_W + RATE_W;
  localparam int STB_W   = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [LEFT_W-1:0] FULL     = LEFT_W'(FRAME_BITS);
  localparam logic [STB_W-1:0]  STB_LIM  = STB_W'(STABLE_CYCLES);

  // receive shifter
  logic [FRAME_BITS-1:0] rxShift;
  logic [CNT_W-1:0]      rxCnt;
  logic                  rxBusy;
  logic [FRAME_BITS-1:0] rxWord;

  assign rxWord   = {rxShift[FRAME_BITS-2:0], sdIn};
  assign wordDone = ctrlMode && rxBusy && !frameStart && (rxCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxCnt   <= '0;
      rxBusy  <= 1'b0;
    end else if (!ctrlMode) begin
      rxBusy  <= 1'b0;
      rxCnt   <= '0;
    end else if (frameStart) begin
      rxShift <= rxWord;
      rxCnt   <= CNT_W'(1);
      rxBusy  <= 1'b1;
    end else if (rxBusy) begin
      rxShift <= rxWord;
      rxCnt   <= rxCnt + CNT_W'(1);
      if (rxCnt == LAST_BIT) rxBusy <= 1'b0;
    end
  end

  // field decode of the word being completed
  logic [SRC_W-1:0]   srcNew;
  logic [FIELD_W-1:0] fieldNew;
  logic [FIELD_W-1:0] prevField;

  assign srcNew       = rxWord[SRC_LSB +: SRC_W];
  assign fieldNew     = {srcNew, rxWord[RATE_LSB +: RATE_W]};
  assign fieldChanged = (fieldNew != prevField);
  assign internalSrc  = (srcNew == SRC_W'(INT_SRC_A)) || (srcNew == SRC_W'(INT_SRC_B));
  assign hsNew        = rxWord[HS_POS];

  // accepted word and configuration
  logic [FRAME_BITS-1:0] echoWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      echoWord  <= '0;
      prevField <= '0;
      cfgImm    <= 1'b0;
    end else if (strb.ctlClear) begin
      echoWord  <= '0;
      prevField <= '0;
    end else if (strb.capture) begin
      echoWord  <= rxWord;
      prevField <= fieldNew;
      cfgImm    <= rxWord[IMM_POS];
    end
  end

  // stability window counter
  logic [STB_W-1:0] stableCnt;
  assign stableOk = (stableCnt == STB_LIM);

  always_ff @(posedge clk) begin
    if (!rstN || strb.ctlClear || strb.clrStable) stableCnt <= '0;
    else if (!stableOk)                           stableCnt <= stableCnt + STB_W'(1);
  end

  // transmit shifter
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] loadWord;
  logic [LEFT_W-1:0]     txLeft;

  always_comb begin
    loadWord         = echoWord;
    loadWord[HS_POS] = echoHs;
  end

  assign txBit  = txShift[FRAME_BITS-1];
  assign txDone = (txLeft == LEFT_W'(1)) && !strb.loadTx;

  always_ff @(posedge clk) begin
    if (!rstN || strb.ctlClear) begin
      txShift <= '0;
      txLeft  <= '0;
    end else if (strb.loadTx) begin
      txShift <= loadWord;
      txLeft  <= FULL;
    end else if (txLeft != '0) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      txLeft  <= txLeft - LEFT_W'(1);
    end
  end

  AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> !wordDone) else $error("word completions too close"); // R1

  AST_STABLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStable && !strb.ctlClear) |=> !stableOk) else $error("stability count not restarted"); // R4

endmodule

// File: rtl/chs_control.sv
module chs_control
  import chs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlMode,
  input  logic       frameStart,
  input  logic       wordDone,
  input  logic       hsNew,
  input  logic       fieldChanged,
  input  logic       internalSrc,
  input  logic       stableOk,
  input  logic       txDone,
  output hskStrobe_t strb,
  output logic       echoHs,
  output hskState_t  state,
  output logic       ctlDrive
);

  logic      pending;
  logic      pendHs;
  logic      accepting;
  logic      fast;
  logic      echoSet;
  logic      echoVal;
  hskState_t stateNext;

  assign accepting     = (state == ST_WAIT0) || (state == ST_ARMED);
  assign fast          = !fieldChanged && (internalSrc || stableOk);
  assign strb.capture  = ctrlMode && wordDone && accepting;
  assign strb.clrStable = strb.capture && fieldChanged;
  assign strb.ctlClear = !ctrlMode;
  assign strb.loadTx   = ctrlMode && frameStart &&
                         (accepting || (state == ST_LOCKED) || (state == ST_FINAL));
  assign ctlDrive      = (state != ST_RELEASED);

  always_comb begin
    echoSet = 1'b0;
    echoVal = pendHs;
    if (strb.capture && fast) begin
      echoSet = 1'b1;
      echoVal = hsNew;
    end else if (!strb.capture && pending && stableOk) begin
      echoSet = 1'b1;
      echoVal = pendHs;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAIT0:    if (echoSet && !echoVal)       stateNext = ST_ARMED;
      ST_ARMED:    if (strb.capture && hsNew)     stateNext = ST_LOCKED;
      ST_LOCKED:   if (echoHs)                    stateNext = ST_FINAL;
      ST_FINAL:    if (strb.loadTx)               stateNext = ST_SENDLAST;
      ST_SENDLAST: if (txDone)                    stateNext = ST_RELEASED;
      ST_RELEASED:                                stateNext = ST_RELEASED;
      default:                                    stateNext = ST_WAIT0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.ctlClear) begin
      state   <= ST_WAIT0;
      echoHs  <= 1'b1;
      pending <= 1'b0;
      pendHs  <= 1'b1;
    end else begin
      state <= stateNext;
      if (echoSet) echoHs <= echoVal;
      if (strb.capture) begin
        pending <= !fast;
        pendHs  <= hsNew;
      end else if (echoSet) begin
        pending <= 1'b0;
      end
    end
  end

  AST_SLOW_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlMode && pending && !stableOk && !wordDone) |=> $stable(echoHs))
    else $error("echo flag moved before stability window"); // R3

  AST_LOCK_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED) |-> !$past(echoHs) || $past(state == ST_LOCKED))
    else $error("locked without a prior zero echo"); // R5

endmodule

// File: rtl/chs_modesync.sv
module chs_modesync #(
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeIn,
  input  logic tsIn,
  input  logic isMaster,
  input  logic cfgImm,
  output logic ctrlMode,
  output logic fsyncOut,
  output logic fsyncEn,
  output logic slotStart
);

  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

  logic modeS1, modeS2;
  logic tsQ, riseD1, riseD2;
  logic begun;
  logic [POS_W-1:0] frmPos;

  // two-flop synchroniser with a matched delay line for the slot rise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeS1 <= 1'b0;
      modeS2 <= 1'b0;
      tsQ    <= 1'b0;
      riseD1 <= 1'b0;
      riseD2 <= 1'b0;
    end else begin
      modeS1 <= modeIn;
      modeS2 <= modeS1;
      tsQ    <= tsIn;
      riseD1 <= tsIn && !tsQ;
      riseD2 <= riseD1;
    end
  end

  assign ctrlMode  = !modeS2;
  assign slotStart = modeS2 && riseD2;

  // master frame sync: one idle period, then a pulse every frame
  always_ff @(posedge clk) begin
    if (!rstN || !modeS2) begin
      begun    <= 1'b0;
      frmPos   <= '0;
      fsyncOut <= 1'b0;
    end else if (!begun) begin
      begun    <= 1'b1;
    end else begin
      fsyncOut <= (frmPos == '0);
      frmPos   <= (frmPos == POS_LAST) ? '0 : frmPos + POS_W'(1);
    end
  end

  assign fsyncEn = isMaster && modeS2 && (modeIn || !cfgImm);

  AST_FSYNC_QUIET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeS2) |=> !fsyncOut) else $error("frame sync too early"); // R8

  AST_FSYNC_SECOND_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (modeS2 && $past(modeS2) && !$past(modeS2, 2)) |=> fsyncOut)
    else $error("frame sync missing on second edge"); // R8

  AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> !slotStart) else $error("slot pulse longer than one cycle"); // R10

endmodule

// File: rtl/ctlmode_handshake.sv
module ctlmode_handshake
  import chs_pkg::*;
#(
  parameter int FRAME_BITS    = 64,
  parameter int HS_POS        = 61,
  parameter int IMM_POS       = 55,
  parameter int SRC_LSB       = 52,
  parameter int SRC_W         = 2,
  parameter int RATE_LSB      = 48,
  parameter int RATE_W        = 3,
  parameter int INT_SRC_A     = 1,
  parameter int INT_SRC_B     = 2,
  parameter int STABLE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeIn,
  input  logic isMaster,
  input  logic frameStart,
  input  logic sdIn,
  input  logic tsIn,
  input  logic dataTx,
  output logic sdOut,
  output logic sdOutEn,
  output logic fsyncOut,
  output logic fsyncEn,
  output logic slotStart
);

  hskStrobe_t strb;
  hskState_t  ctlState;
  logic ctrlMode, echoHs, ctlDrive, cfgImm;
  logic wordDone, hsNew, fieldChanged, internalSrc, stableOk, txDone, txBit;

  chs_modesync #(.FRAME_BITS(FRAME_BITS)) modeSync_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .tsIn(tsIn), .isMaster(isMaster),
    .cfgImm(cfgImm), .ctrlMode(ctrlMode), .fsyncOut(fsyncOut), .fsyncEn(fsyncEn),
    .slotStart(slotStart)
  );

  chs_datapath #(
    .FRAME_BITS(FRAME_BITS), .HS_POS(HS_POS), .IMM_POS(IMM_POS),
    .SRC_LSB(SRC_LSB), .SRC_W(SRC_W), .RATE_LSB(RATE_LSB), .RATE_W(RATE_W),
    .INT_SRC_A(INT_SRC_A), .INT_SRC_B(INT_SRC_B), .STABLE_CYCLES(STABLE_CYCLES)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .frameStart(frameStart),
    .sdIn(sdIn), .strb(strb), .echoHs(echoHs), .wordDone(wordDone),
    .hsNew(hsNew), .fieldChanged(fieldChanged), .internalSrc(internalSrc),
    .stableOk(stableOk), .txDone(txDone), .txBit(txBit), .cfgImm(cfgImm)
  );

  chs_control control_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .frameStart(frameStart),
    .wordDone(wordDone), .hsNew(hsNew), .fieldChanged(fieldChanged),
    .internalSrc(internalSrc), .stableOk(stableOk), .txDone(txDone),
    .strb(strb), .echoHs(echoHs), .state(ctlState), .ctlDrive(ctlDrive)
  );

  assign sdOut   = ctrlMode ? txBit : dataTx;
  assign sdOutEn = ctrlMode ? ctlDrive : 1'b1;

  AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState inside {ST_LOCKED, ST_FINAL, ST_SENDLAST, ST_RELEASED}) |=> $stable(cfgImm))
    else $error("configuration changed after lock"); // R5

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_SENDLAST && txDone && ctrlMode) |=> (!sdOutEn || !ctrlMode))
    else $error("output not released after final word"); // R6

endmodule

// File: tb/ctlmode_handshake_tb_top.sv
module ctlmode_handshake_tb_top;

  localparam int STB = 300;

  logic clk = 1'b0;
  logic rstN, modeIn, isMaster, frameStart, sdIn, tsIn, dataTx;
  logic sdOut, sdOutEn, fsyncOut, fsyncEn, slotStart;
  int   nChecks = 0;
  int   nFails  = 0;

  always #2.5 clk = ~clk;

  ctlmode_handshake #(.STABLE_CYCLES(STB)) dut_i (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .isMaster(isMaster),
    .frameStart(frameStart), .sdIn(sdIn), .tsIn(tsIn), .dataTx(dataTx),
    .sdOut(sdOut), .sdOutEn(sdOutEn), .fsyncOut(fsyncOut), .fsyncEn(fsyncEn),
    .slotStart(slotStart)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(input logic hs, input logic imm,
                                         input logic [1:0] src, input logic [2:0] rate);
    logic [63:0] w = 64'hA5C3_0F96_3C5A_E187;
    w[61]    = hs;
    w[55]    = imm;
    w[53:52] = src;
    w[50:48] = rate;
    return w;
  endfunction

  function automatic logic [63:0] withHs(input logic [63:0] w, input logic hs);
    logic [63:0] r = w;
    r[61] = hs;
    return r;
  endfunction

  task automatic sendFrame(input logic [63:0] w, output logic [63:0] echo);
    echo = '0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i > 0) echo[64 - i] = sdOut;
      sdIn       = w[63 - i];
      frameStart = (i == 0);
    end
    @(negedge clk);
    echo[0]    = sdOut;
    frameStart = 1'b0;
    sdIn       = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0; modeIn = 1'b0; isMaster = 1'b0; frameStart = 1'b0;
    sdIn = 1'b0; tsIn = 1'b0; dataTx = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 sdOutEn", 64'(sdOutEn), 64'd1);
    chk("R11 sdOut", 64'(sdOut), 64'd0);
    chk("R11 fsyncOut", 64'(fsyncOut), 64'd0);
    chk("R11 fsyncEn", 64'(fsyncEn), 64'd0);
    chk("R11 slotStart", 64'(slotStart), 64'd0);
  endtask

  // internal oscillator: delayed first echo, fast second, lock and release
  task automatic tFastPath();
    logic [63:0] e;
    logic [63:0] w0 = mkWord(1'b0, 1'b0, 2'd1, 3'd3);
    logic [63:0] w1 = mkWord(1'b1, 1'b1, 2'd1, 3'd3);
    logic [63:0] w2 = mkWord(1'b0, 1'b0, 2'd0, 3'd7);
    sendFrame(w0, e);
    chk("R11 initial echo", e, withHs(64'd0, 1'b1));
    sendFrame(w0, e);
    chk("R3 changed field delays echo", e, withHs(w0, 1'b1));
    sendFrame(w1, e);
    chk("R2 fast echo of zero", e, withHs(w0, 1'b0));
    sendFrame(w2, e);
    chk("R6 final word with flag set", e, w1);
    chk("R1 echo payload", e[47:0], w1[47:0]);
    chk("R6 enable during last bit", 64'(sdOutEn), 64'd1);
    @(negedge clk);
    chk("R6 released after last bit", 64'(sdOutEn), 64'd0);
    sendFrame(w0, e);
    chk("R5 ignored word leaves output released", 64'(sdOutEn), 64'd0);
  endtask

  task automatic tEnterMaster();
    isMaster = 1'b1;
    @(negedge clk);
    modeIn = 1'b1;
    dataTx = 1'b1;
    @(negedge clk);
    chk("R7 still control after one edge", 64'(sdOutEn), 64'd0);
    @(negedge clk);
    chk("R7 data mode after two edges", 64'(sdOutEn), 64'd1);
    chk("R7 data passthrough", 64'(sdOut), 64'd1);
    chk("R8 no sync at entry", 64'(fsyncOut), 64'd0);
    @(negedge clk);
    chk("R8 no sync first edge", 64'(fsyncOut), 64'd0);
    @(negedge clk);
    chk("R8 sync on second edge", 64'(fsyncOut), 64'd1);
    idle(63);
    chk("R8 sync low before period", 64'(fsyncOut), 64'd0);
    @(negedge clk);
    chk("R8 sync after one period", 64'(fsyncOut), 64'd1);
    chk("R9 sync driven", 64'(fsyncEn), 64'd1);
  endtask

  task automatic tExitImmediate();
    @(negedge clk);
    modeIn = 1'b0;
    dataTx = 1'b0;
    #1;
    chk("R9 immediate release (R5 lock kept bit 55 = 1)", 64'(fsyncEn), 64'd0);
    idle(3);
    chk("R7 control enable restored", 64'(sdOutEn), 64'd1);
  endtask

  // external source: timer window, restart on field change
  task automatic tSlowPath();
    logic [63:0] e;
    logic [63:0] w4 = mkWord(1'b0, 1'b0, 2'd0, 3'd5);
    logic [63:0] w5 = mkWord(1'b1, 1'b0, 2'd0, 3'd6);
    logic [63:0] w6 = mkWord(1'b1, 1'b1, 2'd0, 3'd6);
    sendFrame(w4, e);
    idle(200);
    sendFrame(w4, e);
    chk("R3 external source waits", e, withHs(w4, 1'b1));
    idle(150);
    sendFrame(w4, e);
    chk("R3 echo after window", e, withHs(w4, 1'b0));
    sendFrame(w5, e);
    chk("R3 zero still echoed", e, withHs(w4, 1'b0));
    idle(200);
    sendFrame(w6, e);
    chk("R4 field change restarted window", e, withHs(w5, 1'b0));
    idle(150);
    sendFrame(w4, e);
    chk("R6 R5 locked word echoed with flag", e, withHs(w5, 1'b1));
    @(negedge clk);
    chk("R6 released after slow lock", 64'(sdOutEn), 64'd0);
  endtask

  task automatic tEnterSlave();
    isMaster = 1'b0;
    @(negedge clk);
    modeIn = 1'b1;
    tsIn   = 1'b1;
    @(negedge clk);
    chk("R10 no pulse yet", 64'(slotStart), 64'd0);
    @(negedge clk);
    chk("R10 coincident rise detected", 64'(slotStart), 64'd1);
    chk("R9 slave does not drive sync", 64'(fsyncEn), 64'd0);
    @(negedge clk);
    chk("R10 pulse single cycle", 64'(slotStart), 64'd0);
    dataTx = 1'b0;
    #1;
    chk("R7 data passthrough low", 64'(sdOut), 64'd0);
    isMaster = 1'b1;
    #1;
    chk("R9 master drives sync", 64'(fsyncEn), 64'd1);
  endtask

  task automatic tExitDelayed();
    @(negedge clk);
    modeIn = 1'b0;
    tsIn   = 1'b0;
    #1;
    chk("R9 delayed: held at fall (R5 bit 55 stayed 0)", 64'(fsyncEn), 64'd1);
    @(negedge clk);
    chk("R9 delayed: held one edge", 64'(fsyncEn), 64'd1);
    @(negedge clk);
    chk("R9 delayed: released by second edge", 64'(fsyncEn), 64'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    tReset();
    tFastPath();
    tEnterMaster();
    tExitImmediate();
    tSlowPath();
    tEnterSlave();
    tExitDelayed();
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule